// File: doc/BRIEF.md
# Attenuator and Soft-Mute Gain Controller

This block keeps a 6-bit gain code and uses it to scale a stream of 16-bit signed audio samples. Each sample is multiplied by code/63. A code of 63 passes the sample through unchanged (0 dB). A code of 0 silences it. One saturating up/down counter drives the code in both operating modes.

With `soft_mode_i` low, the block works as a manual attenuator. Each rising edge of the external `step_clk_i` moves the code by one. `mute_dir_i` chooses the direction: high means quieter, low means louder. The step clock is asynchronous, so it is synchronised and edge-detected first.

With `soft_mode_i` high, the step clock has no effect. An internal timer counts sample strobes instead. It moves the code one step toward mute while `mute_dir_i` is high, and one step back toward unity while it is low. A complete ramp spans roughly 1024 sample periods. A change of mode, and reset, return the code to 63.

Top module: `gain_ramp_ctrl`

## Requirements
- R1: After reset, `code_o` is 63 and `smp_o` is 0.
- R2: On a clock edge where `smp_strobe_i` is high, `smp_o` loads the signed product `smp_i` × `code_o`, divided by 63 with truncation toward zero. The code used is the value before that edge. Between strobes `smp_o` holds, and at code 63 it equals the captured sample exactly.
- R3: In manual mode, suppose `step_clk_i` is sampled high at edge n after being sampled low at edge n-1. Then `code_o` changes at edge n+2. It decrements when `mute_dir_i` is 1 and increments when it is 0.
- R4: The code saturates. It stays at 0 when asked to go down and at 63 when asked to go up, and never wraps.
- R5: At the first edge where `soft_mode_i` differs from its value at the previous edge, the code reloads to 63. The soft-mode strobe tally also restarts at zero.
- R6: In soft mode, edges on `step_clk_i` have no effect on `code_o`.
- R7: In soft mode, every 16th strobe moves the code one step: down when `mute_dir_i` is 1, up when it is 0. The code takes effect at that strobe's edge. Going from 63 to 0 takes 1008 strobes, which is within one step of 1024 sample periods.
- R8: In manual mode, sample strobes alone never move the code.
- R9: Each level of `step_clk_i` must be held for at least two clock cycles for a step to be detected. The bench keeps each level for four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_mode_i | input | 1 | 1 = soft-mute ramp, 0 = manual attenuator |
| mute_dir_i | input | 1 | Direction: 1 = toward mute, 0 = toward unity |
| step_clk_i | input | 1 | Asynchronous manual step clock |
| smp_strobe_i | input | 1 | One-cycle pulse per sample period |
| smp_i | input | 16 | Signed audio sample in |
| smp_o | output | 16 | Signed scaled sample out |
| code_o | output | 6 | Current gain code |

## Verification
A scaled sample appears one edge after its strobe. A soft-mode step appears at the edge of the 16th strobe. A manual step appears two edges after the step clock is first sampled high, because it passes through the synchroniser and the edge detector. A mode reload appears one edge after the change is sampled.

The bench keeps a behavioural model that updates at each rising edge from the inputs it drove. It compares both outputs at every falling edge, so each result is checked in exactly the cycle it falls due. Targeted checks then confirm end points, saturation and the cases where the step clock or the strobes are ignored, and these are measured after the pipeline has settled.

// File: rtl/gain_pkg.sv
package gain_pkg;
    localparam int CODE_W = 6;
    localparam int SMP_W  = 16;
    localparam int TICK_W = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/step_sync.sv
module step_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.prev;
endmodule

// File: rtl/gain_counter.sv
module gain_counter
    import gain_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int TW = TICK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_mode_i,
    input  logic          mute_dir_i,
    input  logic          step_rise_i,
    input  logic          strobe_i,
    output logic [CW-1:0] code_o
);
    localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};
    localparam logic [TW-1:0] TICK_MAX = {TW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] code;
        logic [TW-1:0] tick;
        logic          mode;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    adv;

    always_comb begin
        st_d      = st_q;
        st_d.mode = soft_mode_i;
        adv       = 1'b0;
        if (soft_mode_i != st_q.mode) begin
            st_d.code = CODE_MAX;
            st_d.tick = '0;
        end else if (soft_mode_i) begin
            if (strobe_i) begin
                if (st_q.tick == TICK_MAX) begin
                    st_d.tick = '0;
                    adv       = 1'b1;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
        end else begin
            st_d.tick = '0;
            adv       = step_rise_i;
        end
        if (adv) begin
            if (mute_dir_i && st_q.code != '0)
                st_d.code = st_q.code - 1'b1;
            else if (!mute_dir_i && st_q.code != CODE_MAX)
                st_d.code = st_q.code + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= CODE_MAX;
            st_q.tick <= '0;
            st_q.mode <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
    import gain_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int SW = SMP_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_i,
    input  logic signed [SW-1:0] smp_i,
    input  logic [CW-1:0]        code_i,
    output logic signed [SW-1:0] smp_o
);
    localparam int PW = SW + CW + 1;
    localparam logic signed [PW-1:0] DIVISOR = PW'((1 << CW) - 1);

    typedef struct packed {
        logic signed [SW-1:0] out;
    } scl_st_t;

    scl_st_t st_d, st_q;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;

    always_comb begin
        prod = PW'(smp_i) * $signed({{(PW-CW){1'b0}}, code_i});
        quot = prod / DIVISOR;
        st_d = st_q;
        if (strobe_i) st_d.out = quot[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = st_q.out;
endmodule

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
    import gain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_mode_i,
    input  logic              mute_dir_i,
    input  logic              step_clk_i,
    input  logic              smp_strobe_i,
    input  logic [SMP_W-1:0]  smp_i,
    output logic [SMP_W-1:0]  smp_o,
    output logic [CODE_W-1:0] code_o
);
    logic              step_rise;
    logic [CODE_W-1:0] code;
    logic signed [SMP_W-1:0] scaled;

    step_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (step_clk_i),
        .rise_o  (step_rise)
    );

    gain_counter #(.CW(CODE_W), .TW(TICK_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_mode_i (soft_mode_i),
        .mute_dir_i  (mute_dir_i),
        .step_rise_i (step_rise),
        .strobe_i    (smp_strobe_i),
        .code_o      (code)
    );

    gain_scaler #(.CW(CODE_W), .SW(SMP_W)) u_scl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (smp_strobe_i),
        .smp_i    ($signed(smp_i)),
        .code_i   (code),
        .smp_o    (scaled)
    );

    assign smp_o  = scaled;
    assign code_o = code;
endmodule

// File: rtl/gain_ramp_ctrl_chk.sv
module gain_ramp_ctrl_chk
    import gain_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              soft_mode_i,
    input logic              mute_dir_i,
    input logic              smp_strobe_i,
    input logic [SMP_W-1:0]  smp_i,
    input logic [SMP_W-1:0]  smp_o,
    input logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    // R2: output only moves on a strobe
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_strobe_i |=> $stable(smp_o));

    // R2: unity code passes the sample unchanged
    a_r2_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_strobe_i && code_o == TOP) |=> smp_o == $past(smp_i));

    // R4: no wrap below zero in manual mode (reload to top allowed on mode change)
    a_r4_floor_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_mode_i && mute_dir_i && code_o == '0) |=> (code_o == '0 || code_o == TOP));

    // R5: a mode change reloads full gain
    a_r5_mode_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode_i != $past(soft_mode_i)) |=> code_o == TOP);

    // R6 and R7: in soft mode the code moves only on a strobe edge
    a_r6_soft_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_mode_i && !smp_strobe_i) |=> (code_o == $past(code_o) || code_o == TOP));

    // R3: the code moves by at most one step per edge unless reloaded
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (code_o == TOP || code_o == $past(code_o)
                  || code_o == $past(code_o) + 1'b1 || code_o == $past(code_o) - 1'b1));
endmodule

bind gain_ramp_ctrl gain_ramp_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_mode_i  (soft_mode_i),
    .mute_dir_i   (mute_dir_i),
    .smp_strobe_i (smp_strobe_i),
    .smp_i        (smp_i),
    .smp_o        (smp_o),
    .code_o       (code_o)
);

// File: tb/gain_ramp_ctrl_tb_top.sv
`timescale 1ns/1ps
module gain_ramp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_mode_i = 1'b0;
    logic        mute_dir_i = 1'b0;
    logic        step_clk_i = 1'b0;
    logic        smp_strobe_i = 1'b0;
    logic [15:0] smp_i = '0;
    logic [15:0] smp_o;
    logic [5:0]  code_o;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    gain_ramp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .soft_mode_i(soft_mode_i), .mute_dir_i(mute_dir_i),
        .step_clk_i(step_clk_i), .smp_strobe_i(smp_strobe_i), .smp_i(smp_i),
        .smp_o(smp_o), .code_o(code_o)
    );

    // behavioural reference model
    int m_code = 63;
    int m_out = 0;
    int m_tick = 0;
    bit m_mode = 0;
    bit hist[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit edge_seen;
        int old_code;
        if (!rst_n) begin
            m_code = 63; m_out = 0; m_tick = 0; m_mode = 0;
            hist = '{0, 0, 0};
        end else begin
            old_code = m_code;
            edge_seen = hist[1] && !hist[2];
            if (soft_mode_i != m_mode) begin
                m_code = 63; m_tick = 0;
            end else if (soft_mode_i) begin
                if (smp_strobe_i) begin
                    m_tick++;
                    if (m_tick == 16) begin
                        m_tick = 0;
                        if (mute_dir_i && m_code > 0) m_code--;
                        else if (!mute_dir_i && m_code < 63) m_code++;
                    end
                end
            end else if (edge_seen) begin
                if (mute_dir_i && m_code > 0) m_code--;
                else if (!mute_dir_i && m_code < 63) m_code++;
            end
            if (smp_strobe_i) m_out = ($signed(smp_i) * old_code) / 63;
            m_mode = soft_mode_i;
            void'(hist.pop_back());
            hist.push_front(step_clk_i);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " code"}, int'(code_o), m_code);
            check({phase, " out"}, int'($signed(smp_o)), m_out);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_pulse();
        step_clk_i = 1'b1; cyc(4);
        step_clk_i = 1'b0; cyc(4);
    endtask

    task automatic strobe(int s);
        smp_i = 16'(s); smp_strobe_i = 1'b1; cyc(1);
        smp_strobe_i = 1'b0; cyc(1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1
        check("R1 reset code", int'(code_o), 63);
        check("R1 reset out", int'($signed(smp_o)), 0);

        // R2 unity and extremes
        phase = "R2";
        strobe(-32768); check("R2 unity min", int'($signed(smp_o)), -32768);
        strobe(32767);  check("R2 unity max", int'($signed(smp_o)), 32767);

        // R3 manual down five steps
        phase = "R3";
        mute_dir_i = 1'b1;
        for (int i = 0; i < 5; i++) step_pulse();
        check("R3 manual down", int'(code_o), 58);
        strobe(1000); check("R2 scale 1000*58/63", int'($signed(smp_o)), 920);
        strobe(-1000); check("R2 truncation toward zero", int'($signed(smp_o)), -920);

        // R8 strobes in manual mode do not move the code
        phase = "R8";
        for (int i = 0; i < 40; i++) strobe(i * 37);
        check("R8 strobes ignored", int'(code_o), 58);

        // R4 floor
        phase = "R4";
        for (int i = 0; i < 70; i++) step_pulse();
        check("R4 floor", int'(code_o), 0);
        strobe(12345); check("R4 zero code mutes", int'($signed(smp_o)), 0);
        mute_dir_i = 1'b0;
        step_pulse();
        check("R3 manual up", int'(code_o), 1);
        strobe(-100); check("R2 code1 negative", int'($signed(smp_o)), -1);
        for (int i = 0; i < 70; i++) step_pulse();
        check("R4 ceiling", int'(code_o), 63);
        mute_dir_i = 1'b1;
        for (int i = 0; i < 10; i++) step_pulse();
        check("R3 partial down", int'(code_o), 53);

        // R5 reload on entering soft mode
        phase = "R5";
        soft_mode_i = 1'b1; cyc(2);
        check("R5 reload entering soft", int'(code_o), 63);

        // R6 step clock ignored in soft mode
        phase = "R6";
        for (int i = 0; i < 6; i++) step_pulse();
        check("R6 step ignored", int'(code_o), 63);

        // R7 soft ramp down
        phase = "R7";
        for (int i = 0; i < 15; i++) strobe(500);
        check("R7 no step before 16th", int'(code_o), 63);
        strobe(500);
        check("R7 step on 16th", int'(code_o), 62);
        for (int i = 0; i < 1008 - 16; i++) strobe(500);
        check("R7 full mute after 1008", int'(code_o), 0);
        for (int i = 0; i < 32; i++) strobe(500);
        check("R4 soft floor", int'(code_o), 0);
        mute_dir_i = 1'b0;
        for (int i = 0; i < 160; i++) strobe(500);
        check("R7 ramp up", int'(code_o), 10);

        // R5 reload on leaving soft mode
        phase = "R5";
        soft_mode_i = 1'b0; cyc(2);
        check("R5 reload leaving soft", int'(code_o), 63);
        mute_dir_i = 1'b1;
        step_pulse();
        check("R9 four-cycle pulse seen", int'(code_o), 62);

        phase = "R1";
        cyc(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule